// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block controls the output gating of a multi-output system clock generator. It gates four CPU clock outputs and seven stoppable PCI clock outputs. It also passes one free-running PCI output and drives the enables for the crystal oscillator and the VCO. Three requests control it, and all are active low and asynchronous: a power-down request, a CPU-group stop and a PCI-group stop. Each request is synchronized into the clock domain it acts on before it has any effect. Each gate changes only on a falling edge of its own clock, so an output always stops low and never produces a shortened high pulse.

On power-down the CPU and PCI gates close within a few cycles of their own clocks. A sequencer runs on a free-running reference tick. It waits until both domains confirm that their outputs are parked low, and only then drops the oscillator and VCO enables. On wake-up both enables return at once. All gates stay closed while a settle counter on the reference tick runs for `SETTLE_TICKS` ticks. After the count the block reports ready and the gates reopen. Reset enters the same settle phase.

Top module: `clk_stop_seq`

## Requirements
- R1: While reset is asserted, `osc_en` and `vco_en` are 1, `clk_ready` is 0, and `cpu_stopped` and `pci_stopped` are 1. After reset is released, `clk_ready` rises after `SETTLE_TICKS` to `SETTLE_TICKS`+2 reference ticks, and all gates then open.
- R2: On power-down, every CPU, PCI and free-running PCI output is parked low before `osc_en` and `vco_en` fall to 0.
- R3: When `pwrdn_n` goes low, all CPU outputs are held low and `cpu_stopped` is 1 in fewer than three `clk_cpu` cycles.
- R4: While power-down is requested or in effect, `cpu_stop_n` and `pci_stop_n` have no effect: the outputs stay low and the oscillator stays disabled.
- R5: A low `cpu_stop_n` parks only the CPU outputs `cpu_clk_o[3:0]` low and sets `cpu_stopped`. The PCI outputs keep running.
- R6: A low `pci_stop_n` parks only `pci_clk_o[6:0]` low and sets `pci_stopped`. `pci_free_o` and the CPU outputs keep running.
- R7: After `pwrdn_n` returns high, the oscillator and VCO enables come back at once. The outputs stay low until `clk_ready` rises, which happens `SETTLE_TICKS`+1 to `SETTLE_TICKS`+4 reference ticks later. The default of 40000 ticks at a 14.318 MHz tick gives about 2.8 ms, which is under 3 ms.
- R8: A gated output never changes level while its clock is high: each high pulse is either complete or absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU-rate clock from the VCO |
| clk_pci | input | 1 | PCI-rate clock |
| clk_ref | input | 1 | Free-running reference-rate tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Active-low CPU group stop request |
| pci_stop_n | input | 1 | Active-low PCI group stop request |
| cpu_clk_o | output | N_CPU (4) | Gated CPU clock outputs |
| pci_clk_o | output | N_PCI (7) | Gated stoppable PCI clock outputs |
| pci_free_o | output | 1 | Free-running PCI output, gated only by power-down |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| clk_ready | output | 1 | Settle phase finished and block running |
| cpu_stopped | output | 1 | CPU group gate is closed |
| pci_stopped | output | 1 | Stoppable PCI group gate is closed |

## Verification
The assertions assume that `pwrdn_n` stays at each level for several reference ticks, so that the parked acknowledge returning from each domain is never stale. They also assume that all three clocks keep toggling, because the bench models the clock sources as always present. The stimulus therefore holds every request change for many cycles and drives it midway between clock edges. The random phase draws only stop-request combinations while running, and power-down is applied in directed steps.

// File: rtl/clk_stop_seq.sv
`timescale 1ns/100ps
module clk_stop_seq #(
  parameter int N_CPU        = 4,
  parameter int N_PCI        = 7,
  parameter int SETTLE_TICKS = 40000
) (
  input  logic             clk_cpu,
  input  logic             clk_pci,
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             pwrdn_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_o,
  output logic             osc_en,
  output logic             vco_en,
  output logic             clk_ready,
  output logic             cpu_stopped,
  output logic             pci_stopped
);
  localparam int CW = $clog2(SETTLE_TICKS + 1);

  typedef enum logic [1:0] {S_SETTLE, S_RUN, S_PARK, S_OFF} st_t;
  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  pd_r, pk_r;
  logic        run_ok;

  // control domain (reference tick)
  logic cpu_park_q, pci_park_q;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      pd_r <= '0;
      pk_r <= '0;
    end else begin
      pd_r <= {pd_r[0], ~pwrdn_n};
      pk_r <= {pk_r[0], cpu_park_q & pci_park_q};
    end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      st  <= S_SETTLE;
      cnt <= '0;
    end else begin
      case (st)
        S_SETTLE: begin
          if (pd_r[1]) st <= S_PARK;
          else if (cnt == CW'(SETTLE_TICKS - 1)) st <= S_RUN;
          cnt <= cnt + 1'b1;
        end
        S_RUN:  if (pd_r[1]) st <= S_PARK;
        S_PARK: begin
          if (!pd_r[1]) begin
            st  <= S_SETTLE;
            cnt <= '0;
          end else if (pk_r[1]) st <= S_OFF;
        end
        default: if (!pd_r[1]) begin
          st  <= S_SETTLE;
          cnt <= '0;
        end
      endcase
    end

  assign run_ok    = (st == S_RUN);
  assign clk_ready = run_ok;
  assign osc_en    = (st != S_OFF);
  assign vco_en    = (st != S_OFF);

  // CPU domain: {pd, stop, run}
  logic [2:0] c_m, c_s;
  logic       cpu_en_q;
  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) begin
      c_m <= '0;
      c_s <= '0;
    end else begin
      c_m <= {~pwrdn_n, ~cpu_stop_n, run_ok};
      c_s <= c_m;
    end

  always_ff @(negedge clk_cpu or negedge rst_n)
    if (!rst_n) begin
      cpu_en_q   <= 1'b0;
      cpu_park_q <= 1'b0;
    end else begin
      cpu_en_q   <= c_s[0] & ~c_s[1] & ~c_s[2];
      cpu_park_q <= c_s[2];
    end

  // PCI domain: {pd, stop, run}
  logic [2:0] p_m, p_s;
  logic       pci_en_q, pci_free_q;
  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      p_m <= '0;
      p_s <= '0;
    end else begin
      p_m <= {~pwrdn_n, ~pci_stop_n, run_ok};
      p_s <= p_m;
    end

  always_ff @(negedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      pci_en_q   <= 1'b0;
      pci_free_q <= 1'b0;
      pci_park_q <= 1'b0;
    end else begin
      pci_en_q   <= p_s[0] & ~p_s[1] & ~p_s[2];
      pci_free_q <= p_s[0] & ~p_s[2];
      pci_park_q <= p_s[2];
    end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpu_clk_o[i] = clk_cpu & cpu_en_q;
  end
  for (genvar j = 0; j < N_PCI; j++) begin : g_pci
    assign pci_clk_o[j] = clk_pci & pci_en_q;
  end
  assign pci_free_o  = clk_pci & pci_free_q;
  assign cpu_stopped = ~cpu_en_q;
  assign pci_stopped = ~pci_en_q;
endmodule

// File: rtl/clk_stop_seq_chk.sv
`timescale 1ns/100ps
module clk_stop_seq_chk (
  input logic clk_cpu,
  input logic clk_pci,
  input logic clk_ref,
  input logic rst_n,
  input logic pwrdn_n,
  input logic osc_en,
  input logic vco_en,
  input logic clk_ready,
  input logic cpu_en_q,
  input logic pci_en_q,
  input logic pci_free_q
);
  logic [1:0] pd_cnt;
  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) pd_cnt <= '0;
    else if (pwrdn_n) pd_cnt <= '0;
    else if (pd_cnt != 2'd3) pd_cnt <= pd_cnt + 1'b1;

  // R2: enables drop only with every gate parked
  p_park_before_off_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !osc_en |-> (!cpu_en_q && !pci_en_q && !pci_free_q));

  // R3: CPU gate closed within the latency bound
  p_cpu_latency_r3: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (pd_cnt == 2'd3) |-> !cpu_en_q);

  // R6: PCI group stop never closes the free-running output
  p_free_open_r6: assert property (@(posedge clk_pci) disable iff (!rst_n)
    pci_en_q |-> pci_free_q);

  // R7: restart enters the settle phase before ready
  p_settle_first_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(osc_en) |=> !clk_ready);

  // R1: ready only with oscillator and VCO on
  p_ready_enabled_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_ready |-> (osc_en && vco_en));
endmodule

bind clk_stop_seq clk_stop_seq_chk u_chk (
  .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_ref(clk_ref), .rst_n(rst_n),
  .pwrdn_n(pwrdn_n), .osc_en(osc_en), .vco_en(vco_en), .clk_ready(clk_ready),
  .cpu_en_q(cpu_en_q), .pci_en_q(pci_en_q), .pci_free_q(pci_free_q)
);

// File: tb/clk_stop_seq_tb.sv
`timescale 1ns/100ps
module clk_stop_seq_tb;
  localparam int NC = 4, NP = 7, ST = 20;

  logic clk_cpu = 0, clk_pci = 0, clk_ref = 0;
  logic rst_n = 0, pwrdn_n = 1, cpu_stop_n = 1, pci_stop_n = 1;
  logic [NC-1:0] cpu_clk_o;
  logic [NP-1:0] pci_clk_o;
  logic pci_free_o, osc_en, vco_en, clk_ready, cpu_stopped, pci_stopped;
  int nchk = 0, nfail = 0, glitches = 0;

  always #2.5 clk_cpu = ~clk_cpu;
  always #7.5 clk_pci = ~clk_pci;
  always #35  clk_ref = ~clk_ref;

  clk_stop_seq #(.N_CPU(NC), .N_PCI(NP), .SETTLE_TICKS(ST)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_cpu_hi(logic stop_n);
    return stop_n ? '1 : '0;
  endfunction
  function automatic logic [NP-1:0] exp_pci_hi(logic stop_n);
    return stop_n ? '1 : '0;
  endfunction

  // R8: output must not change inside a high phase
  always @(posedge clk_cpu) begin
    logic [NC-1:0] v;
    #0.5 v = cpu_clk_o;
    #1.5 if (cpu_clk_o !== v) glitches++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic check_running(string req, logic cs_n, logic ps_n);
    #150;
    chk(req, cpu_stopped, !cs_n);
    chk(req, pci_stopped, !ps_n);
    @(posedge clk_cpu); #1;
    chk(req, cpu_clk_o, exp_cpu_hi(cs_n));
    @(posedge clk_pci); #1;
    chk(req, pci_clk_o, exp_pci_hi(ps_n));
    chk(req, pci_free_o, 1);
  endtask

  initial begin
    int n;
    int bad;
    void'($urandom(32'h5eed));
    #3;
    chk("R1 reset osc", osc_en, 1);
    chk("R1 reset vco", vco_en, 1);
    chk("R1 reset ready", clk_ready, 0);
    chk("R1 reset gates", {cpu_stopped, pci_stopped}, 2'b11);
    #97 rst_n = 1;
    n = 0;
    while (!clk_ready) begin
      @(posedge clk_ref); #1; n++;
    end
    chk("R1 settle window", (n >= ST && n <= ST + 2), 1);
    check_running("R1 gates open", 1, 1);

    cpu_stop_n = 0;
    check_running("R5 cpu stop", 0, 1);
    cpu_stop_n = 1;
    pci_stop_n = 0;
    check_running("R6 pci stop", 1, 0);
    pci_stop_n = 1;

    for (int k = 0; k < 30; k++) begin
      logic cs, ps;
      cs = 1'($urandom);
      ps = 1'($urandom);
      cpu_stop_n = cs;
      pci_stop_n = ps;
      check_running("R5/R6 random", cs, ps);
    end
    cpu_stop_n = 1;
    pci_stop_n = 1;
    #150;

    @(posedge clk_cpu); #1 pwrdn_n = 0;
    repeat (3) @(posedge clk_cpu);
    #1;
    chk("R3 cpu parked", cpu_stopped, 1);
    chk("R3 cpu outputs", cpu_clk_o, '0);
    chk("R2 osc still on", osc_en, 1);
    wait (!osc_en);
    #1;
    chk("R2 vco off", vco_en, 0);
    chk("R2 groups parked", {cpu_stopped, pci_stopped}, 2'b11);
    @(posedge clk_pci); #1;
    chk("R2 pci outputs", {pci_free_o, pci_clk_o}, '0);

    cpu_stop_n = 0; #200; pci_stop_n = 0; #200;
    cpu_stop_n = 1; #200; pci_stop_n = 1; #300;
    chk("R4 osc held off", osc_en, 0);
    chk("R4 groups parked", {cpu_stopped, pci_stopped}, 2'b11);
    @(posedge clk_pci); #1;
    chk("R4 outputs low", {cpu_clk_o, pci_free_o, pci_clk_o}, '0);

    @(posedge clk_ref); #1 pwrdn_n = 1;
    n = 0; bad = 0;
    while (!clk_ready) begin
      @(posedge clk_ref); #1; n++;
      if (!clk_ready && (cpu_clk_o != 0 || pci_free_o || pci_clk_o != 0)) bad++;
    end
    chk("R7 wake window", (n >= ST + 1 && n <= ST + 4), 1);
    chk("R7 outputs low while settling", bad, 0);
    chk("R7 osc back", {osc_en, vco_en}, 2'b11);
    check_running("R7 gates reopen", 1, 1);

    chk("R8 no short pulses", glitches, 0);
    summary();
  end
endmodule